// File: doc/BRIEF.md
# Prescaled PWM with Switch Routing

This block produces an 8-bit pulse-width-modulated waveform whose counter is stepped by one of eight tick rates. Three of the rates come from a fast clock domain (the fast tick divided by 1, 2 or 4) and five come from a 32.768 kHz domain (that tick divided by 1, 4, 32, 128 or 1024). Both tick inputs are single-cycle pulses already brought into the system clock domain. A sleep flag marks the fast clock as stopped. The three fast rates then yield no counter steps and the waveform is held low.

The waveform can also be routed to analog-switch controls. A single-pole switch is closed by the waveform itself or by its inverse, chosen with a pair of polarity bits. Two double-throw switches each have an enable bit that lets the waveform take over that switch. The configuration is one 8-bit word written through a write strobe. The duty value is a plain input that is compared every cycle.

Top module: `pwm_switch_router`

## Requirements
- R1: While reset is active, and after it is released with no configuration written, every configuration field is 0, `pwm_out` is 0, `sw_close` is 0, and `dt_ovr_en` and `dt_level` are all 0.
- R2: Configuration bit 0 is the run bit. When it is 0, the period counter is held at 0 and `pwm_out` stays low. When it is 1, the counter runs.
- R3: Configuration bits 3:1 select the tick rate. Codes 0, 1 and 2 pass one of every 1, 2 and 4 fast ticks. Codes 3, 4, 5, 6 and 7 pass one of every 1, 4, 32, 128 and 1024 slow ticks.
- R4: While `sleep` is 1 and the rate code is 0, 1 or 2, no counter step occurs and `pwm_out` is 0. `sleep` has no effect on codes 3 to 7.
- R5: The 8-bit period counter advances once per passed tick and wraps from 255 to 0.
- R6: `pwm_out` is 1 while the counter is below `duty`, and 0 from the moment the counter reaches `duty`. A duty of 0 gives a constant low output.
- R7: Configuration bit 4 is the high-polarity bit and bit 5 is the low-polarity bit. With bit 4 = 1 and bit 5 = 0, `sw_close` equals `pwm_out`. With bit 5 = 1 and bit 4 = 0, `sw_close` is the inverse of `pwm_out`.
- R8: When bits 4 and 5 are equal, `sw_close` is 0 (the switch is open) whatever the waveform does.
- R9: Configuration bits 6 and 7 enable double-throw switch 0 and switch 1. For each switch, `dt_ovr_en[i]` equals its enable bit, and `dt_level[i]` equals `pwm_out` when enabled and 0 otherwise.
- R10: A write of the configuration takes effect on the clock edge that samples `cfg_we`. The same edge restarts the tick divider phase at zero. The period counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_tick | input | 1 | Single-cycle tick from the fast clock domain |
| lf_tick | input | 1 | Single-cycle tick from the 32.768 kHz domain |
| sleep | input | 1 | Fast clock stopped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word |
| duty | input | 8 | Duty compare value |
| pwm_out | output | 1 | Raw PWM level |
| sw_close | output | 1 | Single-pole switch close command |
| dt_ovr_en | output | 2 | Double-throw switch takeover enables |
| dt_level | output | 2 | Level driven to each enabled double-throw switch |

## Verification
The fast rates are driven with irregular fast ticks, at duties of 0, 255 and mid-scale. This separates divider phase errors from compare-boundary errors. The slow codes are driven with a steady slow tick, so each divide ratio appears as a distinct step spacing of the counter. Sleep is applied both under a fast code (the output must drop and the counter must freeze) and under a slow code (nothing may change). Every polarity pair and double-throw enable combination is swept while the waveform toggles, and duty is changed mid-period to expose any latching of the compare value.

// File: rtl/pwmsw_pkg.sv
package pwmsw_pkg;

  localparam int NUM_DT  = 2;
  localparam int CFG_W   = 8;
  localparam int RATE_W  = 3;
  localparam int SHIFT_W = 4;

  // Field order fixes the bit positions of the configuration word.
  typedef struct packed {
    logic [NUM_DT-1:0] dt_en;   // bits 7:6
    logic              lo_pol;  // bit 5
    logic              hi_pol;  // bit 4
    logic [RATE_W-1:0] rate;    // bits 3:1
    logic              run;     // bit 0
  } cfg_t;

  // Codes below this value use the fast tick.
  localparam logic [RATE_W-1:0] FIRST_SLOW = 3'd3;

  // log2 of the divide ratio for each rate code
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [RATE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    case (code)
      3'd0:    s = 4'd0;
      3'd1:    s = 4'd1;
      3'd2:    s = 4'd2;
      3'd3:    s = 4'd0;
      3'd4:    s = 4'd2;
      3'd5:    s = 4'd5;
      3'd6:    s = 4'd7;
      default: s = 4'd10;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwmsw_cfg_reg.sv
module pwmsw_cfg_reg
  import pwmsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);

  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R10: a write is visible one edge later
  p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == cfg_t'($past(wdata))));

endmodule

// File: rtl/pwmsw_prescaler.sv
module pwmsw_prescaler
  import pwmsw_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  input  logic              hf_tick,
  input  logic              lf_tick,
  input  logic              sleep,
  output logic              step,
  output logic              src_ok
);

  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] div_m1;
  logic             fast_sel;
  logic             src;
  logic             at_end;
  logic             pre_en;

  assign fast_sel = (rate < FIRST_SLOW);
  assign src      = fast_sel ? (hf_tick & ~sleep) : lf_tick;
  assign div_m1   = (ONE << div_shift(rate)) - ONE;
  assign at_end   = (pre_q == div_m1);
  assign step     = run & src & at_end;
  assign src_ok   = ~(fast_sel & sleep);

  always_comb begin
    pre_en = restart | ~run | src;
    pre_d  = pre_q;
    if (restart || !run) pre_d = '0;
    else if (src)        pre_d = at_end ? '0 : pre_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R4: no steps while the fast source is stopped
  p_no_step_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && fast_sel) |-> !step);

  // R3: divider phase stays inside the selected ratio
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && run && src && !at_end) |=> (pre_q != '0));

  // R10: a write restarts the phase
  p_phase_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));

endmodule

// File: rtl/pwmsw_core.sv
module pwmsw_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             src_ok,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ~run | step;
    cnt_d  = run ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pwm = run & src_ok & (cnt_q < duty);

  // R2: a stopped counter sits at zero
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R5: one advance per step, wrapping
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

  // R5: without a step the counter holds
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt_q));

  // R6: zero duty never goes high
  p_duty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm);

endmodule

// File: rtl/pwmsw_route.sv
module pwmsw_route #(
  parameter int N_DT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm,
  input  logic            hi_pol,
  input  logic            lo_pol,
  input  logic [N_DT-1:0] dt_en,
  output logic            sw_close,
  output logic [N_DT-1:0] dt_ovr_en,
  output logic [N_DT-1:0] dt_level
);

  logic active;

  assign active   = hi_pol ^ lo_pol;
  assign sw_close = active & (hi_pol ? pwm : ~pwm);

  for (genvar i = 0; i < N_DT; i++) begin : g_dt
    assign dt_ovr_en[i] = dt_en[i];
    assign dt_level[i]  = dt_en[i] & pwm;
  end

  // R8: equal polarity bits leave the switch open
  p_sw_open_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pol == lo_pol) |-> !sw_close);

  // R9: a disabled double-throw path never carries the waveform
  p_dt_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dt_level & ~dt_ovr_en) == '0));

endmodule

// File: rtl/pwm_switch_router.sv
module pwm_switch_router
  import pwmsw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hf_tick,
  input  logic             lf_tick,
  input  logic             sleep,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out,
  output logic             sw_close,
  output logic [NUM_DT-1:0] dt_ovr_en,
  output logic [NUM_DT-1:0] dt_level
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cfg_t       cfg;
  logic       step;
  logic       src_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwmsw_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  pwmsw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (cfg.run),
    .restart (cfg_we),
    .rate    (cfg.rate),
    .hf_tick (hf_tick),
    .lf_tick (lf_tick),
    .sleep   (sleep),
    .step    (step),
    .src_ok  (src_ok)
  );

  pwmsw_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (cfg.run),
    .step   (step),
    .src_ok (src_ok),
    .duty   (duty),
    .pwm    (pwm_out)
  );

  pwmsw_route #(.N_DT(NUM_DT)) u_route (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pwm       (pwm_out),
    .hi_pol    (cfg.hi_pol),
    .lo_pol    (cfg.lo_pol),
    .dt_en     (cfg.dt_en),
    .sw_close  (sw_close),
    .dt_ovr_en (dt_ovr_en),
    .dt_level  (dt_level)
  );

  // R1: outputs quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!pwm_out && !sw_close && dt_ovr_en == '0));

endmodule

// File: tb/pwm_switch_router_test.sv
module pwm_switch_router_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hf_tick = 1'b0, lf_tick = 1'b0, sleep = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00, duty = 8'h00;
  logic       pwm_out, sw_close;
  logic [1:0] dt_ovr_en, dt_level;

  int n_cmp = 0, n_bad = 0;
  bit stim_rand = 1'b0;
  int lf_period = 3;

  // reference state
  int m_run, m_rate, m_hi, m_lo, m_dt, m_pre, m_cnt;

  always #10 clk = ~clk;  // 50 MHz

  pwm_switch_router uut (
    .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
    .sleep(sleep), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .duty(duty),
    .pwm_out(pwm_out), .sw_close(sw_close),
    .dt_ovr_en(dt_ovr_en), .dt_level(dt_level)
  );

  function automatic int ratio(int code);
    case (code)
      0: return 1;   1: return 2;   2: return 4;   3: return 1;
      4: return 4;   5: return 32;  6: return 128; default: return 1024;
    endcase
  endfunction

  // R3 R4 R5 R10: reference update on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_rate = 0; m_hi = 0; m_lo = 0; m_dt = 0; m_pre = 0; m_cnt = 0;
    end else begin
      int src, tk;
      src = (m_rate < 3) ? (hf_tick && !sleep) : lf_tick;
      tk  = m_run && src && (m_pre == ratio(m_rate) - 1);
      if (!m_run)  m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) % 256;
      if (cfg_we || !m_run) m_pre = 0;
      else if (src) m_pre = (m_pre == ratio(m_rate) - 1) ? 0 : m_pre + 1;
      if (cfg_we) begin
        m_run = cfg_wdata[0]; m_rate = cfg_wdata[3:1];
        m_hi = cfg_wdata[4]; m_lo = cfg_wdata[5]; m_dt = cfg_wdata[7:6];
      end
    end
  end

  task automatic check1(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    int e_pwm, e_sw;
    if (!rst_n) begin
      e_pwm = 0; e_sw = 0;  // R1
      check1("R1 pwm", pwm_out, 0);
      check1("R1 sw", sw_close, 0);
      check1("R1 dt", {dt_ovr_en, dt_level}, 0);
    end else begin
      e_pwm = (m_run && !(sleep && m_rate < 3) && m_cnt < duty) ? 1 : 0;  // R2 R4 R6
      if (m_hi == m_lo) e_sw = 0;                                        // R8
      else e_sw = m_hi ? e_pwm : 1 - e_pwm;                              // R7
      check1("R6 pwm", pwm_out, e_pwm);
      check1("R7/R8 sw", sw_close, e_sw);
      check1("R9 dt_en", dt_ovr_en, m_dt);
      check1("R9 dt_lvl", dt_level, e_pwm ? m_dt : 0);
    end
  end

  // tick sources
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #2;
      k++;
      hf_tick = stim_rand ? ($urandom_range(0, 1) == 1) : 1'b1;
      lf_tick = (k % lf_period) == 0;
    end
  end

  task automatic wr(logic [7:0] v);
    @(posedge clk); #2; cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #2; cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // field helper: run, rate, hi, lo, dt
  function automatic logic [7:0] cw(int run, int rate, int hi, int lo, int dt);
    return {2'(dt), 1'(lo), 1'(hi), 3'(rate), 1'(run)};
  endfunction

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    // R1: after release with no write everything stays quiet
    check1("R1 idle pwm", pwm_out, 0);
    check1("R1 idle sw", sw_close, 0);

    // R3 R5 R6 R7: fastest rate, steady ticks, mid duty, high polarity
    duty = 8'd100;
    wr(cw(1, 0, 1, 0, 0));
    wait_cyc(700);
    // R2: run bit cleared stops and clears
    wr(cw(0, 0, 1, 0, 0));
    wait_cyc(20);
    check1("R2 stopped", pwm_out, 0);

    // R3: divide by 2 with irregular ticks, duty 0, low polarity (R6 R7)
    stim_rand = 1'b1;
    duty = 8'd0;
    wr(cw(1, 1, 0, 1, 2'b01));
    wait_cyc(1200);
    // R6 R9: full duty, both double-throw paths
    duty = 8'd255;
    wr(cw(1, 2, 1, 0, 2'b11));
    wait_cyc(2500);

    // R4: sleep under a fast code
    duty = 8'd128;
    wait_cyc(100);
    sleep = 1'b1;
    wait_cyc(300);
    sleep = 1'b0;
    wait_cyc(300);

    // R8: equal polarity bits, both set then both clear
    wr(cw(1, 0, 1, 1, 2'b10));
    wait_cyc(600);
    wr(cw(1, 0, 0, 0, 2'b00));
    wait_cyc(300);

    // R10: rewrite mid-phase, counter keeps running
    wr(cw(1, 2, 1, 0, 0));
    wait_cyc(3);
    wr(cw(1, 2, 1, 0, 0));
    wait_cyc(400);

    // R3 R5: slow codes, steady slow tick, duty changed mid-period
    stim_rand = 1'b0;
    lf_period = 2;
    duty = 8'd40;
    wr(cw(1, 3, 1, 0, 1));
    wait_cyc(600);
    duty = 8'd200;
    wait_cyc(600);
    wr(cw(1, 4, 0, 1, 2));
    wait_cyc(3000);
    // R4: sleep ignored on a slow code
    sleep = 1'b1;
    wait_cyc(1500);
    sleep = 1'b0;
    duty = 8'd2;
    wr(cw(1, 5, 1, 0, 3));
    wait_cyc(8000);
    wr(cw(1, 6, 1, 0, 0));
    wait_cyc(6000);
    lf_period = 1;
    duty = 8'd1;
    wr(cw(1, 7, 1, 0, 3));
    wait_cyc(5000);

    // R1: reset in mid-run
    rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(20);
    check1("R1 after reset", {pwm_out, sw_close, dt_ovr_en}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule